// File: doc/BRIEF.md
# Performance Counter Read Gating

This block answers read requests aimed at the counter registers of a processor's control space. It keeps one 64-bit count of retired instructions, which serves every cycle and instret register at both the user level and the machine level. For each read it decides whether to return a value, to raise an illegal-instruction trap or to raise a virtual-instruction trap. The decision uses the register address, the current privilege level, the virtualization bit, the register width mode, and three counter-enable masks: one from machine level, one from the hypervisor and one from supervisor level.

A read is a single-beat transaction. A request (address plus the privilege and mask context on the plain control pins) is taken when `req_valid` and `req_ready` are both high. The result appears on a response channel on the next cycle. The response is held until `rsp_ready` is high. The request side applies back-pressure by lowering `req_ready` while an unconsumed response is waiting. The retire pulse is a plain input and is never stalled.

Privilege encoding on `priv`: 0 is user, 1 is supervisor and 3 is machine. `xlen64` high selects 64-bit mode and low selects 32-bit mode.

Top module: `cnt_read_gate`

## Requirements
- R1: The retired-instruction count is zero after reset and increases by one on every clock edge where `retire` is high.
- R2: Addresses 0xB00, 0xB02, 0xC00 and 0xC02 (when permitted) return the count as it stood at the accepting edge, before that edge's increment. In 64-bit mode all 64 bits are returned; in 32-bit mode bits [31:0] are returned, zero-extended.
- R3: Addresses 0xB80, 0xB82, 0xC80 and 0xC82 return count bits [63:32] in 32-bit mode. In 64-bit mode they raise illegal-instruction.
- R4: For an address of the form 0xCxx, the enable bit is bit addr[4:0] of a mask built as follows. The mask is all ones in machine mode. Below machine mode it is ANDed with `men`. When V=1 it is also ANDed with `hen`. In user mode it is also ANDed with `sen`.
- R5: A read of 0xC00, 0xC02, 0xC80 or 0xC82 whose enable bit is clear raises virtual-instruction when V=1, `men` bit addr[4:0] is 1 and `hen` bit addr[4:0] is 0. In every other case it raises illegal-instruction.
- R6: User event counters 0xC03–0xC1F return zero when enabled. Their 32-bit-only high halves 0xC83–0xC9F also return zero when enabled. When disabled they raise illegal-instruction, never virtual-instruction, whatever the value of V.
- R7: Machine-level addresses (addr[9:8]=3) need machine mode and ignore all masks. Reads of 0xB03–0xB1F, of 0xB83–0xB9F (32-bit mode only), of 0x323–0x33F and of 0x320 return zero. Any machine-level read made below machine mode raises illegal-instruction and never virtual-instruction.
- R8: Every address not named in R2, R3, R6 and R7 raises illegal-instruction. This includes 0xC01, 0x321 and 0x322.
- R9: A trapping response carries zero data, and no response raises both traps at once.
- R10: A response is valid on the cycle after acceptance. `req_ready` is high exactly when no response is pending or `rsp_ready` is high. A pending response keeps its data and flags stable until it is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Read request can be taken |
| req_addr | input | 12 | Register address |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt | input | 1 | Virtualization bit |
| xlen64 | input | 1 | 1 for 64-bit mode, 0 for 32-bit mode |
| men | input | 32 | Machine-level counter-enable mask |
| hen | input | 32 | Hypervisor-level counter-enable mask |
| sen | input | 32 | Supervisor-level counter-enable mask |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 64 | Read value (zero on a trap) |
| rsp_illegal | output | 1 | Illegal-instruction trap |
| rsp_virtual | output | 1 | Virtual-instruction trap |

## Verification
The checks assume that `priv` never carries the reserved value 2 and that `virt` is only high below machine mode. The trap-selection rules give no meaning to other combinations. The directed stimulus only drives privilege levels 0, 1 and 3, and it pairs V=1 with user or supervisor mode. The context pins are sampled at acceptance only, so the bench holds them steady with `req_valid`. Retire pulses are kept away from reads, except in the back-pressure scenario. There the bench deliberately retires during a stall to show that the captured value is frozen.

// File: rtl/cnt_gate_pkg.sv
package cnt_gate_pkg;
  localparam int ADDR_W = 12;
  localparam int SLOTS  = 32;
  localparam int IDX_W  = $clog2(SLOTS);
  localparam int GRP_W  = ADDR_W - IDX_W;

  localparam logic [1:0] PRV_USER  = 2'd0;
  localparam logic [1:0] PRV_SUPER = 2'd1;
  localparam logic [1:0] PRV_MACH  = 2'd3;

  // group bases: the address above its slot index
  localparam logic [ADDR_W-1:0] U_LO_BASE = 12'hC00;
  localparam logic [ADDR_W-1:0] U_HI_BASE = 12'hC80;
  localparam logic [ADDR_W-1:0] M_LO_BASE = 12'hB00;
  localparam logic [ADDR_W-1:0] M_HI_BASE = 12'hB80;
  localparam logic [ADDR_W-1:0] EVT_BASE  = 12'h320;

  localparam logic [IDX_W-1:0] SLOT_CYC = 5'd0;
  localparam logic [IDX_W-1:0] SLOT_RET = 5'd2;
  localparam logic [IDX_W-1:0] SLOT_EV0 = 5'd3;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_UCNT,
    CLS_UCNTH,
    CLS_UHPM,
    CLS_UHPMH,
    CLS_MCNT,
    CLS_MCNTH,
    CLS_MZERO
  } cls_e;

  typedef struct packed {
    logic ill;
    logic vrt;
  } trap_t;

  function automatic logic [GRP_W-1:0] grp_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction
endpackage

// File: rtl/retire_counter.sv
module retire_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (retire) cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign count = cnt_q;
endmodule

// File: rtl/enable_mask.sv
module enable_mask
  import cnt_gate_pkg::*;
(
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic [SLOTS-1:0] men,
  input  logic [SLOTS-1:0] hen,
  input  logic [SLOTS-1:0] sen,
  output logic [SLOTS-1:0] en
);
  always_comb begin
    en = '1;
    if (priv != PRV_MACH) begin
      en = en & men;
      if (virt) en = en & hen;
      if (priv == PRV_USER) en = en & sen;
    end
  end
endmodule

// File: rtl/csr_class_decode.sv
module csr_class_decode
  import cnt_gate_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              xlen64,
  output cls_e              cls,
  output logic [IDX_W-1:0]  idx
);
  logic [GRP_W-1:0] grp;
  logic is_cnt, is_ev;

  assign grp    = grp_of(addr);
  assign idx    = addr[IDX_W-1:0];
  assign is_cnt = (idx == SLOT_CYC) || (idx == SLOT_RET);
  assign is_ev  = (idx >= SLOT_EV0);

  always_comb begin
    cls = CLS_NONE;
    if (grp == grp_of(U_LO_BASE)) begin
      if (is_cnt)     cls = CLS_UCNT;
      else if (is_ev) cls = CLS_UHPM;
    end else if (grp == grp_of(U_HI_BASE)) begin
      if (!xlen64) begin
        if (is_cnt)     cls = CLS_UCNTH;
        else if (is_ev) cls = CLS_UHPMH;
      end
    end else if (grp == grp_of(M_LO_BASE)) begin
      if (is_cnt)     cls = CLS_MCNT;
      else if (is_ev) cls = CLS_MZERO;
    end else if (grp == grp_of(M_HI_BASE)) begin
      if (!xlen64) begin
        if (is_cnt)     cls = CLS_MCNTH;
        else if (is_ev) cls = CLS_MZERO;
      end
    end else if (grp == grp_of(EVT_BASE)) begin
      // slot 0 is the inhibit control, slots 3.. are event selectors
      if (idx == SLOT_CYC || is_ev) cls = CLS_MZERO;
    end
  end
endmodule

// File: rtl/read_resolve.sv
module read_resolve
  import cnt_gate_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  cls_e             cls,
  input  logic [IDX_W-1:0] idx,
  input  logic [SLOTS-1:0] en,
  input  logic [SLOTS-1:0] men,
  input  logic [SLOTS-1:0] hen,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             xlen64,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] data,
  output trap_t            trap
);
  localparam int HALF = CNT_W / 2;

  logic             en_bit, hyp_only;
  logic             is_mach;
  logic [CNT_W-1:0] lo_val, hi_val;

  assign en_bit   = en[idx];
  assign hyp_only = virt & men[idx] & ~hen[idx];
  assign is_mach  = (priv == PRV_MACH);
  assign lo_val   = xlen64 ? count : {{HALF{1'b0}}, count[HALF-1:0]};
  assign hi_val   = {{HALF{1'b0}}, count[CNT_W-1:HALF]};

  always_comb begin
    data = '0;
    trap = '0;
    unique case (cls)
      CLS_UCNT, CLS_UCNTH: begin
        if (en_bit)        data = (cls == CLS_UCNT) ? lo_val : hi_val;
        else if (hyp_only) trap.vrt = 1'b1;
        else               trap.ill = 1'b1;
      end
      CLS_UHPM, CLS_UHPMH: begin
        if (!en_bit) trap.ill = 1'b1;
      end
      CLS_MCNT, CLS_MCNTH: begin
        if (is_mach) data = (cls == CLS_MCNT) ? lo_val : hi_val;
        else         trap.ill = 1'b1;
      end
      CLS_MZERO: begin
        if (!is_mach) trap.ill = 1'b1;
      end
      default: trap.ill = 1'b1;
    endcase
  end
endmodule

// File: rtl/cnt_read_gate.sv
module cnt_read_gate
  import cnt_gate_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [11:0]      req_addr,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             xlen64,
  input  logic [31:0]      men,
  input  logic [31:0]      hen,
  input  logic [31:0]      sen,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_data,
  output logic             rsp_illegal,
  output logic             rsp_virtual
);
  logic [CNT_W-1:0] count;
  logic [SLOTS-1:0] en;
  cls_e             cls;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] res_data;
  trap_t            res_trap;
  logic             accept;

  retire_counter #(.CNT_W(CNT_W)) cnt_u (
    .clk(clk), .rst_n(rst_n), .retire(retire), .count(count)
  );

  enable_mask mask_u (
    .priv(priv), .virt(virt), .men(men), .hen(hen), .sen(sen), .en(en)
  );

  csr_class_decode dec_u (
    .addr(req_addr), .xlen64(xlen64), .cls(cls), .idx(idx)
  );

  read_resolve #(.CNT_W(CNT_W)) res_u (
    .cls(cls), .idx(idx), .en(en), .men(men), .hen(hen), .priv(priv),
    .virt(virt), .xlen64(xlen64), .count(count),
    .data(res_data), .trap(res_trap)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_illegal <= 1'b0;
      rsp_virtual <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_data    <= res_data;
      rsp_illegal <= res_trap.ill;
      rsp_virtual <= res_trap.vrt;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/cnt_read_gate_chk.sv
module cnt_read_gate_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire,
  input logic             req_valid,
  input logic             req_ready,
  input logic [11:0]      req_addr,
  input logic [1:0]       priv,
  input logic             virt,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [CNT_W-1:0] rsp_data,
  input logic             rsp_illegal,
  input logic             rsp_virtual,
  input logic [CNT_W-1:0] count
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> count == $past(count) + 1'b1);

  // R9
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_illegal && rsp_virtual));

  // R9
  trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_illegal || rsp_virtual)) |-> rsp_data == '0);

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data)
      && $stable(rsp_illegal) && $stable(rsp_virtual));

  // R7
  mach_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[9:8] == 2'b11 && priv != 2'b11)
      |=> rsp_illegal && !rsp_virtual);

  // R5
  virt_needs_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !virt) |=> !rsp_virtual);
endmodule

bind cnt_read_gate cnt_read_gate_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .retire(retire), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .priv(priv), .virt(virt),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_illegal(rsp_illegal), .rsp_virtual(rsp_virtual), .count(count)
);

// File: tb/cnt_read_gate_tb_top.sv
module cnt_read_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic [1:0]  priv = 2'd3;
  logic        virt = 1'b0;
  logic        xlen64 = 1'b1;
  logic [31:0] men = '0, hen = '0, sen = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        rsp_illegal, rsp_virtual;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_cnt = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cnt_read_gate dut_i (
    .clk(clk), .rst_n(rst_n), .retire(retire), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .priv(priv), .virt(virt),
    .xlen64(xlen64), .men(men), .hen(hen), .sen(sen),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_illegal(rsp_illegal), .rsp_virtual(rsp_virtual)
  );

  task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctx(input logic [1:0] p, input logic v, input logic x64,
                     input logic [31:0] m, input logic [31:0] h, input logic [31:0] s);
    priv = p; virt = v; xlen64 = x64; men = m; hen = h; sen = s;
  endtask

  // one read; result compared as {data, illegal, virtual}
  task automatic rd(input string tag, input logic [11:0] a,
                    input logic [63:0] ed, input logic ei, input logic ev);
    @(negedge clk);
    req_addr = a; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {65'd0, rsp_valid}, 66'd1);
    check(tag, {rsp_data, rsp_illegal, rsp_virtual}, {ed, ei, ev});
  endtask

  task automatic pulse_retire(input int n);
    @(negedge clk);
    retire = 1'b1;
    repeat (n) @(negedge clk);
    retire = 1'b0;
    exp_cnt += 64'(n);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 reset rsp_valid", {65'd0, rsp_valid}, 66'd0);
    check("R10 reset req_ready", {65'd0, req_ready}, 66'd1);
    ctx(2'd3, 1'b0, 1'b1, '0, '0, '0);
    rd("R1 count zero after reset", 12'hB00, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_count;
    pulse_retire(5);
    ctx(2'd3, 1'b0, 1'b1, '0, '0, '0);
    rd("R1 R2 mcycle after 5", 12'hB00, exp_cnt, 1'b0, 1'b0);
    rd("R2 minstret", 12'hB02, exp_cnt, 1'b0, 1'b0);
    pulse_retire(37);
    rd("R2 cycle 64-bit", 12'hC00, exp_cnt, 1'b0, 1'b0);
    ctx(2'd3, 1'b0, 1'b0, '0, '0, '0);
    rd("R2 instret 32-bit", 12'hC02, {32'd0, exp_cnt[31:0]}, 1'b0, 1'b0);
    rd("R3 cycle high 32-bit", 12'hC80, {32'd0, exp_cnt[63:32]}, 1'b0, 1'b0);
    rd("R3 mcycle high 32-bit", 12'hB80, {32'd0, exp_cnt[63:32]}, 1'b0, 1'b0);
    ctx(2'd3, 1'b0, 1'b1, '0, '0, '0);
    rd("R3 instret high 64-bit", 12'hC82, 64'd0, 1'b1, 1'b0);
    rd("R3 minstret high 64-bit", 12'hB82, 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_enable;
    ctx(2'd0, 1'b0, 1'b1, 32'h5, 32'h0, 32'h0);
    rd("R4 user blocked by sen", 12'hC00, 64'd0, 1'b1, 1'b0);
    ctx(2'd1, 1'b0, 1'b1, 32'h5, 32'h0, 32'h0);
    rd("R4 supervisor ignores sen", 12'hC00, exp_cnt, 1'b0, 1'b0);
    ctx(2'd1, 1'b0, 1'b1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd("R4 men bit 2 clear", 12'hC02, 64'd0, 1'b1, 1'b0);
    ctx(2'd1, 1'b1, 1'b1, 32'h4, 32'h4, 32'h0);
    rd("R4 virtual supervisor with hen", 12'hC02, exp_cnt, 1'b0, 1'b0);
    ctx(2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
    rd("R4 user all enabled", 12'hC00, exp_cnt, 1'b0, 1'b0);
  endtask

  task automatic t_virtual;
    ctx(2'd0, 1'b1, 1'b1, 32'h4, 32'h0, 32'hFFFF_FFFF);
    rd("R5 hen-only denial", 12'hC02, 64'd0, 1'b0, 1'b1);
    ctx(2'd0, 1'b1, 1'b1, 32'h0, 32'h0, 32'hFFFF_FFFF);
    rd("R5 men denial with V", 12'hC02, 64'd0, 1'b1, 1'b0);
    ctx(2'd0, 1'b1, 1'b1, 32'h5, 32'h5, 32'h0);
    rd("R5 sen denial with V", 12'hC00, 64'd0, 1'b1, 1'b0);
    ctx(2'd1, 1'b1, 1'b0, 32'h1, 32'h0, 32'h0);
    rd("R5 high half hen-only", 12'hC80, 64'd0, 1'b0, 1'b1);
  endtask

  task automatic t_hpm;
    ctx(2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
    rd("R6 disabled event ctr no virtual", 12'hC05, 64'd0, 1'b1, 1'b0);
    ctx(2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
    rd("R6 enabled event ctr zero", 12'hC1F, 64'd0, 1'b0, 1'b0);
    ctx(2'd3, 1'b0, 1'b0, '0, '0, '0);
    rd("R6 event high 32-bit zero", 12'hC85, 64'd0, 1'b0, 1'b0);
    ctx(2'd3, 1'b0, 1'b1, '0, '0, '0);
    rd("R6 event high 64-bit", 12'hC85, 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_machine;
    ctx(2'd3, 1'b0, 1'b1, '0, '0, '0);
    rd("R7 mcycle ignores masks", 12'hB00, exp_cnt, 1'b0, 1'b0);
    rd("R7 machine event ctr zero", 12'hB04, 64'd0, 1'b0, 1'b0);
    rd("R7 event selector zero", 12'h323, 64'd0, 1'b0, 1'b0);
    rd("R7 inhibit zero", 12'h320, 64'd0, 1'b0, 1'b0);
    rd("R7 machine event high 64-bit", 12'hB84, 64'd0, 1'b1, 1'b0);
    ctx(2'd3, 1'b0, 1'b0, '0, '0, '0);
    rd("R7 machine event high 32-bit", 12'hB84, 64'd0, 1'b0, 1'b0);
    ctx(2'd1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd("R7 selector from guest", 12'h323, 64'd0, 1'b1, 1'b0);
    rd("R7 mcycle from supervisor", 12'hB00, 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_unknown;
    ctx(2'd3, 1'b0, 1'b1, '0, '0, '0);
    rd("R8 slot 1", 12'hC01, 64'd0, 1'b1, 1'b0);
    rd("R8 selector slot 1", 12'h321, 64'd0, 1'b1, 1'b0);
    rd("R8 unrelated address", 12'h800, 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_backpressure;
    logic [63:0] held;
    ctx(2'd3, 1'b0, 1'b1, '0, '0, '0);
    held = exp_cnt;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 12'hB02; req_valid = 1'b1; retire = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R10 stalled valid/ready", {64'd0, rsp_valid, req_ready}, {64'd0, 2'b10});
      check("R10 stalled data frozen", {rsp_data, rsp_illegal, rsp_virtual}, {held, 2'b00});
      @(negedge clk);
    end
    retire = 1'b0;
    exp_cnt += 64'd4;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 released", {65'd0, rsp_valid}, 66'd0);
    rd("R1 count after stall retires", 12'hB00, exp_cnt, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_enable();
    t_virtual();
    t_hpm();
    t_machine();
    t_unknown();
    t_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule